// File: doc/BRIEF.md
# Keyed Bootloader Entry Gate

This block is a small register slave that guards entry into a privileged bootloader mode. Software unlocks the mode by writing an exact, ordered series of eight byte values to one trigger register. Only when the last value of that series lands does the block raise its mode flag. While the flag is set, the block holds the application device disabled through a dedicated output, and an identification register returns a fixed signature that software can use to confirm the unlock.

A control register exposes a constant version field that is always readable. It also has a write-only exit bit that drops the mode flag again. A byte written to the trigger register that breaks the series restarts the match. If that byte is itself the first value of the key, it is counted as a fresh start rather than thrown away. The bus is a single-cycle write strobe with a byte address, and the read data is a combinational function of the address.

Top module: `boot_unlock_gate`

## Requirements
- R1: After reset the mode flag is clear, `app_disable` is 0 and the match position is at the start of the key.
- R2: The trigger register is at byte offset 0x04. Only bits 7:0 of a write to it take part in the match, and bits 31:8 are ignored. It always reads back as 0x00000000.
- R3: Writing the key 0xDE, 0xAD, 0xBE, 0xEF, 0xCA, 0xFE, 0xBA, 0xBE to the trigger register in that order sets the mode. `app_disable` reads 1 on the clock edge that takes the eighth write, and not before.
- R4: A trigger write whose byte differs both from the expected key byte and from 0xDE returns the match to the start. After such a write, the full eight-byte key is needed again.
- R5: A trigger write whose byte differs from the expected key byte but equals 0xDE counts as the first key byte. Seven further correct bytes then unlock.
- R6: The register at byte offset 0x0C reads 0x53564543 while the mode is set and 0x00000000 otherwise.
- R7: The control register at byte offset 0x00 reads the constant version 2 in bits 21:14, with all other bits 0, which gives 0x00008000.
- R8: A write to the control register with bit 6 set clears the mode, and `app_disable` reads 0 after that edge. A control write with bit 6 clear has no effect on the mode.
- R9: The match position is held at the start while the mode is set and on leaving it. Trigger writes made during the mode neither change it nor count toward a later unlock.
- R10: Writes to offsets other than the trigger register do not change the match position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| app_disable | output | 1 | High while bootloader mode is set; holds the application device off |

## Verification
Two matcher actions coincide in one cycle when a mismatching trigger byte is itself 0xDE: the restart of the match and the advance past the first key position happen on the same edge. The bench provokes this in two ways. It sends a key whose third byte is 0xDE and then continues with the whole key from that point. It also sends 0xDE twice before the rest. In both cases it judges the outcome only through `app_disable` after the final byte, expecting the unlock with exactly seven correct bytes after the restarting one. It also sends a mismatch with a different byte, which must need all eight bytes again.

// File: rtl/bul_pkg.sv
package bul_pkg;
  localparam int KEY_LEN = 8;
  localparam int IDX_W   = $clog2(KEY_LEN);
  localparam int BYTE_W  = 8;

  localparam int OFF_CTRL = 0;
  localparam int OFF_TRIG = 4;
  localparam int OFF_ID   = 12;

  localparam int EXIT_BIT = 6;
  localparam int VER_LSB  = 14;
  localparam int VER_W    = 8;

  localparam logic [31:0] ID_SIGNATURE = 32'h5356_4543;

  // Expected byte at each key position
  function automatic logic [BYTE_W-1:0] key_byte(input logic [IDX_W-1:0] pos);
    case (pos)
      3'd0:    return 8'hDE;
      3'd1:    return 8'hAD;
      3'd2:    return 8'hBE;
      3'd3:    return 8'hEF;
      3'd4:    return 8'hCA;
      3'd5:    return 8'hFE;
      3'd6:    return 8'hBA;
      default: return 8'hBE;
    endcase
  endfunction

  // Position after a trigger byte: advance on a hit, restart otherwise,
  // counting a stray first-key byte as a fresh start.
  function automatic logic [IDX_W-1:0] next_pos(input logic [IDX_W-1:0] pos,
                                                input logic [BYTE_W-1:0] b);
    if (b == key_byte(pos))
      return (pos == IDX_W'(KEY_LEN - 1)) ? '0 : pos + 1'b1;
    else if (b == key_byte('0))
      return IDX_W'(1);
    else
      return '0;
  endfunction

  function automatic logic key_complete(input logic [IDX_W-1:0] pos,
                                        input logic [BYTE_W-1:0] b);
    return (pos == IDX_W'(KEY_LEN - 1)) && (b == key_byte(pos));
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [VER_W-1:0] ver);
    return 32'(ver) << VER_LSB;
  endfunction
endpackage

// File: rtl/bul_seq_matcher.sv
module bul_seq_matcher
  import bul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_we,
  input  logic [BYTE_W-1:0] trig_byte,
  input  logic              hold,
  output logic [IDX_W-1:0]  pos_q,
  output logic              key_done
);
  logic step;
  assign step     = trig_we && !hold;
  assign key_done = step && key_complete(pos_q, trig_byte);

  always_ff @(posedge clk) begin
    if (!rst_n)      pos_q <= '0;
    else if (hold)   pos_q <= '0;
    else if (step)   pos_q <= next_pos(pos_q, trig_byte);
  end

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && trig_byte != key_byte(pos_q) && trig_byte != key_byte('0)) |=> (pos_q == '0));

  // R5
  first_byte_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && trig_byte != key_byte(pos_q) && trig_byte == key_byte('0)) |=> (pos_q == IDX_W'(1)));

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_we && !hold) |=> $stable(pos_q));
endmodule

// File: rtl/bul_mode_reg.sv
module bul_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic key_done,
  input  logic exit_req,
  output logic mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (key_done) mode_q <= 1'b1;
    else if (exit_req) mode_q <= 1'b0;
  end

  // R3
  unlock_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> mode_q);

  // R8
  exit_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !mode_q);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_done && !exit_req) |=> $stable(mode_q));
endmodule

// File: rtl/bul_rd_mux.sv
module bul_rd_mux
  import bul_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int VERSION = 2
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              mode,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFF_CTRL))
      rd_data = DATA_W'(ctrl_word(VER_W'(VERSION)));
    else if (rd_addr == ADDR_W'(OFF_ID) && mode)
      rd_data = DATA_W'(ID_SIGNATURE);
  end
endmodule

// File: rtl/boot_unlock_gate.sv
module boot_unlock_gate
  import bul_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int VERSION = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              app_disable
);
  // Named events for the assertions
  logic             trig_we;
  logic             ctrl_we;
  logic             exit_req;
  logic             key_done;
  logic             mode_q;
  logic [IDX_W-1:0] pos_q;

  assign trig_we  = bus_we && (bus_addr == ADDR_W'(OFF_TRIG));
  assign ctrl_we  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
  assign exit_req = ctrl_we && bus_wdata[EXIT_BIT] && mode_q;

  bul_seq_matcher u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_we   (trig_we),
    .trig_byte (bus_wdata[BYTE_W-1:0]),
    .hold      (mode_q),
    .pos_q     (pos_q),
    .key_done  (key_done)
  );

  bul_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_done (key_done),
    .exit_req (exit_req),
    .mode_q   (mode_q)
  );

  bul_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_rd (
    .rd_addr (bus_addr),
    .mode    (mode_q),
    .rd_data (bus_rdata)
  );

  assign app_disable = mode_q;

  // R9
  pos_clear_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> (pos_q == '0));

  // R9
  pos_held_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $past(mode_q)) |-> (pos_q == '0));
endmodule

// File: tb/boot_unlock_gate_test.sv
module boot_unlock_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          app_disable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_unlock_gate uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .app_disable(app_disable)
  );

  localparam logic [7:0] K0 = 8'hDE, K1 = 8'hAD, K2 = 8'hBE, K3 = 8'hEF,
                         K4 = 8'hCA, K5 = 8'hFE, K6 = 8'hBA, K7 = 8'hBE;
  localparam logic [31:0] SIG  = 32'h5356_4543;
  localparam logic [31:0] CTRL = 32'h0000_8000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic trig(input logic [7:0] b);
    wr(8'h04, {24'h0, b});
  endtask

  task automatic full_key();
    trig(K0); trig(K1); trig(K2); trig(K3);
    trig(K4); trig(K5); trig(K6); trig(K7);
  endtask

  task automatic leave();
    wr(8'h00, 32'h40);
  endtask

  task automatic t_reset();
    check("R1 app_disable after reset", {31'h0, app_disable}, 32'h0);
    rd_check("R6 id idle", 8'h0C, 32'h0);
    rd_check("R7 ctrl version", 8'h00, CTRL);
    rd_check("R2 trigger reads zero", 8'h04, 32'h0);
  endtask

  task automatic t_unlock();
    trig(K0); trig(K1); trig(K2); trig(K3); trig(K4); trig(K5); trig(K6);
    check("R3 not before last byte", {31'h0, app_disable}, 32'h0);
    trig(K7);
    check("R3 unlocked on last byte", {31'h0, app_disable}, 32'h1);
    rd_check("R6 id in mode", 8'h0C, SIG);
    rd_check("R2 trigger reads zero in mode", 8'h04, 32'h0);
    rd_check("R7 ctrl version in mode", 8'h00, CTRL);
  endtask

  task automatic t_exit();
    wr(8'h00, 32'hFFFF_FFBF);
    check("R8 bit6 clear keeps mode", {31'h0, app_disable}, 32'h1);
    leave();
    check("R8 exit clears mode", {31'h0, app_disable}, 32'h0);
    rd_check("R6 id after exit", 8'h0C, 32'h0);
    leave();
    check("R8 exit when idle", {31'h0, app_disable}, 32'h0);
  endtask

  task automatic t_wrong();
    trig(K0); trig(K1); trig(K2); trig(8'h00);
    trig(K3); trig(K4); trig(K5); trig(K6); trig(K7);
    check("R4 wrong byte restarts", {31'h0, app_disable}, 32'h0);
    full_key();
    check("R4 full key after restart", {31'h0, app_disable}, 32'h1);
    leave();
    // upper bits of trigger writes are ignored
    wr(8'h04, 32'hFFFF_FF00 | K0); wr(8'h04, 32'hA5A5_A500 | K1);
    wr(8'h04, 32'h1234_5600 | K2); wr(8'h04, 32'h8000_0000 | K3);
    wr(8'h04, 32'h0101_0100 | K4); wr(8'h04, 32'h7F00_0000 | K5);
    wr(8'h04, 32'h0000_FF00 | K6); wr(8'h04, 32'hDEAD_BE00 | K7);
    check("R2 upper bits ignored", {31'h0, app_disable}, 32'h1);
    leave();
  endtask

  task automatic t_restart_first();
    trig(K0); trig(K1); trig(8'hDE);
    trig(K1); trig(K2); trig(K3); trig(K4); trig(K5); trig(K6); trig(K7);
    check("R5 stray DE restarts at one", {31'h0, app_disable}, 32'h1);
    leave();
    trig(8'hDE); full_key();
    check("R5 repeated DE", {31'h0, app_disable}, 32'h1);
    leave();
  endtask

  task automatic t_ignored_in_mode();
    full_key();
    trig(K0); trig(K1);
    check("R9 trigger in mode no effect", {31'h0, app_disable}, 32'h1);
    leave();
    trig(K2); trig(K3); trig(K4); trig(K5); trig(K6); trig(K7);
    check("R9 no carry-over after exit", {31'h0, app_disable}, 32'h0);
    full_key();
    check("R9 full key after exit", {31'h0, app_disable}, 32'h1);
    leave();
  endtask

  task automatic t_other_offsets();
    trig(K0); trig(K1); trig(K2);
    wr(8'h08, 32'h55); wr(8'h0C, 32'hFF); wr(8'h00, 32'h0);
    trig(K3); trig(K4); trig(K5); trig(K6); trig(K7);
    check("R10 other writes keep position", {31'h0, app_disable}, 32'h1);
    leave();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_exit();
    t_wrong();
    t_restart_first();
    t_ignored_in_mode();
    t_other_offsets();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule